// File: doc/BRIEF.md
# Vectored interrupt priority controller

This block tracks 256 interrupt vectors for one processor. Each vector has a request bit and an in-service bit, held as eight 32-bit words per register. A task priority value and a stack of nested in-service vectors together give the processor priority. The block uses that priority to decide whether the highest requested vector may be offered to the processor.

The processor accepts the offered vector with a strobe. The vector then moves from requested to in-service and is pushed on the nesting stack. An end-of-interrupt strobe retires the highest vector in service. Priorities are compared by class, which is the upper four bits of the vector. Vectors 0 to 31 are reserved and are never offered or retired by the scans.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request for vector n sets bit (n mod 32) of request word (n / 32). The word is readable on the request read port after the next clock edge.
- R2: The pending search looks at request words 7 down to 1 and picks the highest set bit of the first nonzero word. Vectors 0..31 are never offered.
- R3: The vector found by the search is offered (pend_valid=1) only if its class (vector[7:4]) is strictly greater than the class of ppr. Otherwise nothing is offered, even if lower words hold requests.
- R4: An accept of vector v clears request bit v, sets in-service bit v and pushes v on the nesting stack.
- R5: ppr equals the task priority when the task priority class is at least the class of the stack top (an empty stack counts as 0). Otherwise ppr equals the stack top with bits [3:0] cleared.
- R6: End-of-interrupt clears the highest set in-service bit in words 7..1 and pops the stack. With nothing in service it changes nothing.
- R7: A task priority write keeps only tpr_wdata[7:0], and ppr reflects it after the next clock edge.
- R8: The stack holds STACK_DEPTH (16) vectors. An accept while the stack is full sets a sticky ovf_err flag and changes nothing else.
- R9: A request arriving in the same cycle as an accept of a different vector is recorded.
- R10: After reset the request and in-service words, the task priority, ppr, pend_valid and ovf_err are all zero.
- R11: When an accept is carried out in the same cycle as end-of-interrupt, the accept takes effect and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Raise a request this cycle |
| req_vec | input | 8 | Vector being requested |
| accept | input | 1 | Processor takes accept_vec into service |
| accept_vec | input | 8 | Vector being accepted |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 32 | Task priority write data, low byte kept |
| pend_valid | output | 1 | A vector is offered |
| pend_vec | output | 8 | Offered vector |
| ppr | output | 8 | Processor priority |
| irr_sel | input | 3 | Request word select |
| irr_word | output | 32 | Selected request word |
| isr_sel | input | 3 | In-service word select |
| isr_word | output | 32 | Selected in-service word |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
Every state change is registered once. A request, accept, end-of-interrupt or priority write applied before a rising edge therefore shows up on ppr, pend_valid, pend_vec, ovf_err and the read words right after that edge. The offer and the priority follow the registers through combinational logic, and the read words follow the select inputs in the same way, so no further cycles of latency are added. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It checks outputs at that point, one rising edge after the stimulus, and sets the word selects a time step before it samples them.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int VEC_W  = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CLS_LO = 4;

    typedef logic [VEC_W-1:0] vec_t;

    function automatic logic [VEC_W-CLS_LO-1:0] prio_cls(vec_t v);
        return v[VEC_W-1:CLS_LO];
    endfunction
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     bits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_word_scan.sv
module irq_word_scan #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int VEC_W     = 8,
    localparam int IDX_W    = $clog2(WORD_W)
) (
    input  logic [NUM_WORDS*WORD_W-1:0] bits,
    output logic                        found,
    output logic [VEC_W-1:0]            vec
);
    logic               any_a [NUM_WORDS-1:1];
    logic [IDX_W-1:0]   idx_a [NUM_WORDS-1:1];
    logic               unused_w0;

    assign unused_w0 = ^bits[WORD_W-1:0];

    for (genvar g = 1; g < NUM_WORDS; g++) begin : g_word
        irq_msb_find #(.W(WORD_W)) u_msb (
            .bits (bits[g*WORD_W +: WORD_W]),
            .any  (any_a[g]),
            .idx  (idx_a[g])
        );
    end

    // The highest nonzero word wins; word 0 is never searched.
    always_comb begin
        found = 1'b0;
        vec   = '0;
        for (int w = 1; w < NUM_WORDS; w++) begin
            if (any_a[w]) begin
                found = 1'b1;
                vec   = VEC_W'(w * WORD_W + int'(idx_a[w]));
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int STACK_DEPTH = 16,
    localparam int NUM_WORDS  = NUM_VEC / WORD_W,
    localparam int SEL_W      = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_vec,
    input  logic              accept,
    input  logic [7:0]        accept_vec,
    input  logic              eoi,
    input  logic              tpr_we,
    input  logic [31:0]       tpr_wdata,
    output logic              pend_valid,
    output logic [7:0]        pend_vec,
    output logic [7:0]        ppr,
    input  logic [SEL_W-1:0]  irr_sel,
    output logic [WORD_W-1:0] irr_word,
    input  logic [SEL_W-1:0]  isr_sel,
    output logic [WORD_W-1:0] isr_word,
    output logic              ovf_err
);
    localparam int SP_W = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        logic [NUM_VEC-1:0]                irr;
        logic [NUM_VEC-1:0]                isr;
        logic [VEC_W-1:0]                  tpr;
        logic [STACK_DEPTH-1:0][VEC_W-1:0] stk;
        logic [SP_W-1:0]                   sp;
        logic                              ovf;
    } state_t;

    state_t st_d, st_q;

    logic       irr_found, isr_found;
    vec_t       irr_top, isr_top;
    vec_t       stk_top;
    logic       full;
    logic       unused_hi;

    assign unused_hi = ^tpr_wdata[31:8];

    irq_word_scan #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .VEC_W(VEC_W)) u_irr_scan (
        .bits  (st_q.irr),
        .found (irr_found),
        .vec   (irr_top)
    );

    irq_word_scan #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .VEC_W(VEC_W)) u_isr_scan (
        .bits  (st_q.isr),
        .found (isr_found),
        .vec   (isr_top)
    );

    // Stack top, with an empty stack reading as vector 0.
    always_comb begin
        stk_top = '0;
        for (int i = 0; i < STACK_DEPTH; i++) begin
            if (i + 1 == int'(st_q.sp)) stk_top = st_q.stk[i];
        end
    end

    assign full = (int'(st_q.sp) == STACK_DEPTH);
    assign ppr  = (prio_cls(st_q.tpr) >= prio_cls(stk_top)) ?
                  st_q.tpr : {stk_top[VEC_W-1:CLS_LO], {CLS_LO{1'b0}}};

    assign pend_valid = irr_found && (prio_cls(irr_top) > prio_cls(ppr));
    assign pend_vec   = pend_valid ? irr_top : '0;

    assign irr_word = st_q.irr[irr_sel*WORD_W +: WORD_W];
    assign isr_word = st_q.isr[isr_sel*WORD_W +: WORD_W];
    assign ovf_err  = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (accept && full) begin
            st_d.ovf = 1'b1;
        end else if (accept) begin
            st_d.irr[accept_vec] = 1'b0;
            st_d.isr[accept_vec] = 1'b1;
            for (int i = 0; i < STACK_DEPTH; i++) begin
                if (i == int'(st_q.sp)) st_d.stk[i] = accept_vec;
            end
            st_d.sp = st_q.sp + 1'b1;
        end else if (eoi && isr_found) begin
            st_d.isr[isr_top] = 1'b0;
            if (st_q.sp != '0) st_d.sp = st_q.sp - 1'b1;
        end
        if (req_valid) st_d.irr[req_vec] = 1'b1;
        if (tpr_we)    st_d.tpr = tpr_wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int STACK_DEPTH = 16,
    parameter int SP_W        = 5,
    parameter int NV          = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            accept,
    input logic [7:0]      accept_vec,
    input logic            eoi,
    input logic            tpr_we,
    input logic [7:0]      tpr_wdata8,
    input logic            pend_valid,
    input logic [7:0]      pend_vec,
    input logic [7:0]      ppr,
    input logic [7:0]      tpr,
    input logic [NV-1:0]   isr,
    input logic [SP_W-1:0] sp,
    input logic            ovf
);
    // R2: reserved vectors are never offered
    p_pend_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> pend_vec >= 8'd32);

    // R3: the offer always outranks the processor priority
    p_pend_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> pend_vec[7:4] > ppr[7:4]);

    // R4: an accepted vector is in service and pushed
    p_acc_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && int'(sp) < STACK_DEPTH) |=> isr[$past(accept_vec)]);

    p_acc_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && int'(sp) < STACK_DEPTH) |=> sp == $past(sp) + 1'b1);

    // R5: processor priority never drops below the task priority
    p_ppr_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr);

    // R6: end-of-interrupt with nothing in service is harmless
    p_eoi_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !accept && sp == '0) |=> (sp == '0) && $stable(isr));

    // R7: task priority write lands on the next edge
    p_tpr_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_we |=> tpr == $past(tpr_wdata8));

    // R8: overflow is sticky and a full-stack accept changes nothing
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_full_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && int'(sp) == STACK_DEPTH && !eoi) |=> $stable(isr) && $stable(sp));
endmodule

bind irq_prio_ctrl irq_prio_chk #(
    .STACK_DEPTH (STACK_DEPTH),
    .SP_W        (SP_W),
    .NV          (NUM_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .accept_vec (accept_vec),
    .eoi        (eoi),
    .tpr_we     (tpr_we),
    .tpr_wdata8 (tpr_wdata[7:0]),
    .pend_valid (pend_valid),
    .pend_vec   (pend_vec),
    .ppr        (ppr),
    .tpr        (st_q.tpr),
    .isr        (st_q.isr),
    .sp         (st_q.sp),
    .ovf        (st_q.ovf)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        accept = 1'b0;
    logic [7:0]  accept_vec = '0;
    logic        eoi = 1'b0;
    logic        tpr_we = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        pend_valid;
    logic [7:0]  pend_vec;
    logic [7:0]  ppr;
    logic [2:0]  irr_sel = '0;
    logic [31:0] irr_word;
    logic [2:0]  isr_sel = '0;
    logic [31:0] isr_word;
    logic        ovf_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk, .rst_n, .req_valid, .req_vec, .accept, .accept_vec, .eoi,
        .tpr_we, .tpr_wdata, .pend_valid, .pend_vec, .ppr,
        .irr_sel, .irr_word, .isr_sel, .isr_word, .ovf_err
    );

    // op: 0 request, 1 accept, 2 end-of-interrupt, 3 task priority write
    // fields: {op, arg, expected pend_valid, expected pend_vec, expected ppr}
    localparam int NT = 15;
    localparam logic [50:0] TBL [NT] = '{
        {2'd0, 32'h045, 1'b1, 8'h45, 8'h00},
        {2'd0, 32'h010, 1'b1, 8'h45, 8'h00},
        {2'd1, 32'h045, 1'b0, 8'h00, 8'h40},
        {2'd3, 32'h04A, 1'b0, 8'h00, 8'h4A},
        {2'd3, 32'h000, 1'b0, 8'h00, 8'h40},
        {2'd0, 32'h047, 1'b0, 8'h00, 8'h40},
        {2'd0, 32'h062, 1'b1, 8'h62, 8'h40},
        {2'd1, 32'h062, 1'b0, 8'h00, 8'h60},
        {2'd3, 32'h075, 1'b0, 8'h00, 8'h75},
        {2'd3, 32'h020, 1'b0, 8'h00, 8'h60},
        {2'd2, 32'h000, 1'b0, 8'h00, 8'h40},
        {2'd2, 32'h000, 1'b1, 8'h47, 8'h20},
        {2'd2, 32'h000, 1'b1, 8'h47, 8'h20},
        {2'd3, 32'h150, 1'b0, 8'h00, 8'h50},
        {2'd3, 32'h000, 1'b1, 8'h47, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        req_valid = 1'b0; accept = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
    endtask

    // Inputs are set just after a falling edge; this waits one rising edge
    // and returns at the next falling edge with the inputs removed.
    task automatic settle();
        @(negedge clk);
        idle_all();
    endtask

    task automatic read_irr(input logic [2:0] s, output logic [31:0] w);
        irr_sel = s; #1; w = irr_word;
    endtask

    task automatic read_isr(input logic [2:0] s, output logic [31:0] w);
        isr_sel = s; #1; w = isr_word;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ppr", {24'h0, ppr}, 32'h0);
        chk("R10 pend_valid", {31'h0, pend_valid}, 32'h0);
        chk("R10 ovf_err", {31'h0, ovf_err}, 32'h0);
        read_irr(3'd2, w); chk("R10 irr word", w, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NT; k++) begin
            logic [1:0]  op;
            logic [31:0] arg;
            op  = TBL[k][50:49];
            arg = TBL[k][48:17];
            case (op)
                2'd0: begin req_valid = 1'b1; req_vec = arg[7:0]; end
                2'd1: begin accept = 1'b1; accept_vec = arg[7:0]; end
                2'd2: eoi = 1'b1;
                default: begin tpr_we = 1'b1; tpr_wdata = arg; end
            endcase
            settle();
            // R2, R3: offer decision; R5 with R4/R6/R7: priority after each step
            chk($sformatf("R2,R3 step %0d pend_valid", k), {31'h0, pend_valid}, {31'h0, TBL[k][16]});
            if (TBL[k][16])
                chk($sformatf("R2 step %0d pend_vec", k), {24'h0, pend_vec}, {24'h0, TBL[k][15:8]});
            chk($sformatf("R5,R7 step %0d ppr", k), {24'h0, ppr}, {24'h0, TBL[k][7:0]});
        end

        // R1: bit placement of requests 0x47 and 0x10
        read_irr(3'd2, w); chk("R1 irr word2", w, 32'h0000_0080);
        read_irr(3'd0, w); chk("R1 irr word0", w, 32'h0001_0000);

        // R9: request of 0xA3 in the same cycle as accept of 0x47
        accept = 1'b1; accept_vec = 8'h47; req_valid = 1'b1; req_vec = 8'hA3;
        settle();
        read_irr(3'd5, w); chk("R9 irr word5", w, 32'h0000_0008);
        read_irr(3'd2, w); chk("R4 irr word2 cleared", w, 32'h0);
        read_isr(3'd2, w); chk("R4 isr word2", w, 32'h0000_0080);
        chk("R9 pend_vec", {23'h0, pend_valid, pend_vec}, {23'h0, 1'b1, 8'hA3});
        chk("R5 ppr", {24'h0, ppr}, 32'h40);

        // R11: accept 0xA3 with end-of-interrupt in the same cycle
        accept = 1'b1; accept_vec = 8'hA3; eoi = 1'b1;
        settle();
        read_isr(3'd5, w); chk("R11 isr word5", w, 32'h0000_0008);
        read_isr(3'd2, w); chk("R11 isr word2 kept", w, 32'h0000_0080);
        chk("R11 ppr", {24'h0, ppr}, 32'hA0);

        // R6: retire highest first, then nothing left
        eoi = 1'b1; settle();
        read_isr(3'd5, w); chk("R6 isr word5", w, 32'h0);
        read_isr(3'd2, w); chk("R6 isr word2", w, 32'h0000_0080);
        chk("R6 ppr", {24'h0, ppr}, 32'h40);
        eoi = 1'b1; settle();
        chk("R6 ppr empty", {24'h0, ppr}, 32'h0);
        eoi = 1'b1; settle();
        read_isr(3'd2, w); chk("R6 eoi when empty", w, 32'h0);

        // R8: fill the stack, then overflow
        for (int i = 0; i < 16; i++) begin
            accept = 1'b1; accept_vec = 8'h30 + 8'(i);
            settle();
        end
        read_isr(3'd1, w); chk("R4 isr word1 full", w, 32'hFFFF_0000);
        chk("R8 no ovf yet", {31'h0, ovf_err}, 32'h0);
        accept = 1'b1; accept_vec = 8'h80;
        settle();
        chk("R8 ovf set", {31'h0, ovf_err}, 32'h1);
        read_isr(3'd4, w); chk("R8 accept ignored", w, 32'h0);
        chk("R8 ppr unchanged", {24'h0, ppr}, 32'h30);
        settle();
        chk("R8 ovf sticky", {31'h0, ovf_err}, 32'h1);

        // R10: reset mid-run clears everything
        rst_n = 1'b0; #1;
        chk("R10 ovf cleared", {31'h0, ovf_err}, 32'h0);
        read_isr(3'd1, w); chk("R10 isr cleared", w, 32'h0);
        chk("R10 ppr cleared", {24'h0, ppr}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule